// File: doc/BRIEF.md
# Variable Page Size TLB

This block is a fully associative, software-loaded translation buffer shared by the instruction and data sides of a 32-bit core. Each of its entries maps one effective page to one real page. The page size is chosen per entry from eight sizes, starting at 1 KB and growing by a factor of four up to 16 MB. An entry also carries a translation ID. It takes part in a lookup only when that ID equals the process ID currently held in the block.

Software fills entries through an index-addressed write port and sets the process ID through its own load strobe. A requester presents an effective address and names its side, instruction or data. One cycle later the block returns a single response, which is one of three: a translated real address, an untranslated pass-through when that side has translation switched off, or a translation fault raised on the requesting side. The search compares all entries in parallel. When several entries match, the one with the lowest index wins.

The response path is a small state machine with five states. RSP_IDLE means no request was presented in the previous cycle. RSP_XLAT_HIT means an entry matched. RSP_BYPASS means translation was off for that side. RSP_IFAULT and RSP_DFAULT mean a miss on the instruction or data side. Every state is entered directly from any state at each clock edge, based only on the request of that cycle:
- no request goes to RSP_IDLE;
- a request with translation off goes to RSP_BYPASS;
- a request that finds a match goes to RSP_XLAT_HIT;
- a request that finds no match goes to RSP_IFAULT or RSP_DFAULT, depending on its side.

Asynchronous reset forces RSP_IDLE.

Top module: `vpt_tlb`

## Requirements
- R1: Reset clears the valid flag of every entry, so a translated lookup made after reset, before any load, faults.
- R2: When wr_en is high at a clock edge, the entry at wr_idx takes wr_hi, wr_lo and wr_tid. Lookups requested from the next cycle on see the new contents. A lookup requested in the same cycle as the write still sees the old contents.
- R3: An entry is eligible only if its valid flag (wr_hi bit 6) is 1 and its translation ID equals the current process ID.
- R4: The size code s in wr_hi bits 9:7 selects a page of 1 KB × 4^s. The compare mask is all ones shifted left by 10+2s, which gives values from 0xFFFFFC00 for s=0 to 0xFF000000 for s=7.
- R5: An eligible entry matches when the effective address and the entry's high word agree in every bit set in that entry's mask. High-word bits outside the mask are ignored.
- R6: On a match, the response address is (low word AND mask) OR (effective address AND NOT mask).
- R7: When several eligible entries match, the lowest-indexed one supplies the result.
- R8: With translation on for the requesting side (lk_side 0 = instruction, 1 = data) and no match, rsp_ifault (side 0) or rsp_dfault (side 1) is raised alone, with rsp_hit low and rsp_pa zero.
- R9: With translation off for the requesting side (xlat_en_i for side 0, xlat_en_d for side 1), rsp_pa equals the effective address, and rsp_hit and both fault flags stay low.
- R10: A request in one cycle yields rsp_valid in the next. In a cycle after no request, all response outputs are zero.
- R11: The process ID resets to 0 and loads pid_in on a clock edge where pid_we is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Entry load strobe |
| wr_idx | input | $clog2(ENTRIES) | Entry index to load |
| wr_hi | input | 32 | High word: page number 31:10, size code 9:7, valid 6 |
| wr_lo | input | 32 | Low word: real page number in the bits kept by the mask |
| wr_tid | input | TID_W | Translation ID for the entry |
| pid_we | input | 1 | Process ID load strobe |
| pid_in | input | TID_W | New process ID |
| lk_req | input | 1 | Lookup request |
| lk_side | input | 1 | Requesting side: 0 instruction, 1 data |
| lk_ea | input | 32 | Effective address |
| xlat_en_i | input | 1 | Translation enable, instruction side |
| xlat_en_d | input | 1 | Translation enable, data side |
| rsp_valid | output | 1 | Response present |
| rsp_hit | output | 1 | Entry matched |
| rsp_ifault | output | 1 | Instruction-side translation fault |
| rsp_dfault | output | 1 | Data-side translation fault |
| rsp_pa | output | 32 | Real address |

## Verification
The bench probes the edges of the size masks:
- An address one byte past a 1 KB page must miss. A design that used a mask one size too wide would hit instead.
- High-word bits below a 4 KB mask must be ignored. An unmasked compare would miss.
- A 1 MB entry with junk in its low-word offset bits must drop those bits from the real address.

It places a 16 KB entry inside a 16 MB entry at a higher index. A design that let the last match win, rather than the first, would return the wrong real address. Once the 16 MB entry is cleared, the 16 KB entry must win.

Translation ID filtering is tested by switching the process ID between two overlapping entries. Side handling is tested by disabling only one side, which catches a fault raised on the wrong side or an enable taken from the wrong side. A load in the same cycle as a lookup catches a search that reads the entry store before it is written. A second reset catches valid flags that survive reset.

// File: rtl/vpt_tlb_pkg.sv
package vpt_tlb_pkg;
    localparam int VA_W         = 32;
    localparam int SZ_W         = 3;
    localparam int MIN_PG_SHIFT = 10;
    localparam int HI_VALID_BIT = 6;
    localparam int HI_SZ_LSB    = 7;

    typedef logic [VA_W-1:0] addr_t;
    typedef logic [SZ_W-1:0] pgsz_t;

    typedef enum logic [2:0] {
        RSP_IDLE     = 3'd0,
        RSP_XLAT_HIT = 3'd1,
        RSP_BYPASS   = 3'd2,
        RSP_IFAULT   = 3'd3,
        RSP_DFAULT   = 3'd4
    } rsp_state_e;

    // Compare mask: each size step quadruples the page.
    function automatic addr_t page_mask(input pgsz_t sz);
        addr_t ones;
        ones = '1;
        return ones << (MIN_PG_SHIFT + 2 * int'(sz));
    endfunction
endpackage

// File: rtl/vpt_tlb_store.sv
module vpt_tlb_store
    import vpt_tlb_pkg::*;
#(
    parameter  int ENTRIES = 64,
    parameter  int TID_W   = 8,
    localparam int IDX_W   = $clog2(ENTRIES)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               wr_en,
    input  logic [IDX_W-1:0]   wr_idx,
    input  addr_t              wr_hi,
    input  addr_t              wr_lo,
    input  logic [TID_W-1:0]   wr_tid,
    output logic [ENTRIES-1:0] ent_valid,
    output addr_t              ent_hi  [ENTRIES],
    output addr_t              ent_lo  [ENTRIES],
    output logic [TID_W-1:0]   ent_tid [ENTRIES]
);

    for (genvar e = 0; e < ENTRIES; e++) begin : g_ent
        logic sel;
        assign sel = wr_en && (wr_idx == IDX_W'(e));

        // Valid flags are the only reset state.
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                ent_valid[e] <= 1'b0;
            end else if (sel) begin
                ent_valid[e] <= wr_hi[HI_VALID_BIT];
            end
        end

        always_ff @(posedge clk) begin
            if (sel) begin
                ent_hi[e]  <= wr_hi;
                ent_lo[e]  <= wr_lo;
                ent_tid[e] <= wr_tid;
            end
        end
    end

    // R2
    wr_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> ent_valid[$past(wr_idx)] == $past(wr_hi[HI_VALID_BIT]));

endmodule

// File: rtl/vpt_tlb_search.sv
module vpt_tlb_search
    import vpt_tlb_pkg::*;
#(
    parameter int ENTRIES = 64,
    parameter int TID_W   = 8
) (
    input  addr_t              ea,
    input  logic [TID_W-1:0]   pid,
    input  logic [ENTRIES-1:0] ent_valid,
    input  addr_t              ent_hi  [ENTRIES],
    input  addr_t              ent_lo  [ENTRIES],
    input  logic [TID_W-1:0]   ent_tid [ENTRIES],
    output logic               found,
    output addr_t              pa
);

    logic [ENTRIES-1:0] match;
    addr_t              emask [ENTRIES];

    for (genvar e = 0; e < ENTRIES; e++) begin : g_cmp
        assign emask[e] = page_mask(ent_hi[e][HI_SZ_LSB +: SZ_W]);
        assign match[e] = ent_valid[e]
                       && (ent_tid[e] == pid)
                       && (((ea ^ ent_hi[e]) & emask[e]) == '0);
    end

    // Walk downward so the lowest matching index is the one left standing.
    always_comb begin
        found = 1'b0;
        pa    = '0;
        for (int e = ENTRIES - 1; e >= 0; e--) begin
            if (match[e]) begin
                found = 1'b1;
                pa    = (ent_lo[e] & emask[e]) | (ea & ~emask[e]);
            end
        end
    end

endmodule

// File: rtl/vpt_tlb.sv
module vpt_tlb
    import vpt_tlb_pkg::*;
#(
    parameter  int ENTRIES = 64,
    parameter  int TID_W   = 8,
    localparam int IDX_W   = $clog2(ENTRIES)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [IDX_W-1:0] wr_idx,
    input  logic [31:0]      wr_hi,
    input  logic [31:0]      wr_lo,
    input  logic [TID_W-1:0] wr_tid,
    input  logic             pid_we,
    input  logic [TID_W-1:0] pid_in,
    input  logic             lk_req,
    input  logic             lk_side,
    input  logic [31:0]      lk_ea,
    input  logic             xlat_en_i,
    input  logic             xlat_en_d,
    output logic             rsp_valid,
    output logic             rsp_hit,
    output logic             rsp_ifault,
    output logic             rsp_dfault,
    output logic [31:0]      rsp_pa
);

    logic [ENTRIES-1:0] ent_valid;
    addr_t              ent_hi  [ENTRIES];
    addr_t              ent_lo  [ENTRIES];
    logic [TID_W-1:0]   ent_tid [ENTRIES];
    logic [TID_W-1:0]   pid_q;
    logic               srch_found;
    addr_t              srch_pa;
    logic               xlat_on;
    rsp_state_e         st_q, st_d;
    addr_t              pa_q, pa_d;

    vpt_tlb_store #(.ENTRIES(ENTRIES), .TID_W(TID_W)) u_store (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en     (wr_en),
        .wr_idx    (wr_idx),
        .wr_hi     (wr_hi),
        .wr_lo     (wr_lo),
        .wr_tid    (wr_tid),
        .ent_valid (ent_valid),
        .ent_hi    (ent_hi),
        .ent_lo    (ent_lo),
        .ent_tid   (ent_tid)
    );

    vpt_tlb_search #(.ENTRIES(ENTRIES), .TID_W(TID_W)) u_search (
        .ea        (lk_ea),
        .pid       (pid_q),
        .ent_valid (ent_valid),
        .ent_hi    (ent_hi),
        .ent_lo    (ent_lo),
        .ent_tid   (ent_tid),
        .found     (srch_found),
        .pa        (srch_pa)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pid_q <= '0;
        end else if (pid_we) begin
            pid_q <= pid_in;
        end
    end

    assign xlat_on = lk_side ? xlat_en_d : xlat_en_i;

    // Next-state selection from this cycle's request.
    always_comb begin
        st_d = RSP_IDLE;
        pa_d = '0;
        if (lk_req) begin
            if (!xlat_on) begin
                st_d = RSP_BYPASS;
                pa_d = lk_ea;
            end else if (srch_found) begin
                st_d = RSP_XLAT_HIT;
                pa_d = srch_pa;
            end else begin
                st_d = lk_side ? RSP_DFAULT : RSP_IFAULT;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= RSP_IDLE;
            pa_q <= '0;
        end else begin
            st_q <= st_d;
            pa_q <= pa_d;
        end
    end

    always_comb begin
        rsp_valid  = 1'b0;
        rsp_hit    = 1'b0;
        rsp_ifault = 1'b0;
        rsp_dfault = 1'b0;
        rsp_pa     = pa_q;
        unique case (st_q)
            RSP_IDLE:     rsp_pa     = '0;
            RSP_XLAT_HIT: begin rsp_valid = 1'b1; rsp_hit    = 1'b1; end
            RSP_BYPASS:   rsp_valid  = 1'b1;
            RSP_IFAULT:   begin rsp_valid = 1'b1; rsp_ifault = 1'b1; end
            RSP_DFAULT:   begin rsp_valid = 1'b1; rsp_dfault = 1'b1; end
            default:      rsp_pa     = '0;
        endcase
    end

    // R10
    req_resp_chk: assert property (@(posedge clk) disable iff (!rst_n)
        lk_req |=> rsp_valid);

    // R10
    idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !lk_req |=> (!rsp_valid && !rsp_hit && !rsp_ifault && !rsp_dfault && rsp_pa == '0));

    // R9
    bypass_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (lk_req && !(lk_side ? xlat_en_d : xlat_en_i))
        |=> (rsp_pa == $past(lk_ea) && !rsp_hit && !rsp_ifault && !rsp_dfault));

    // R8
    dside_no_ifault_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (lk_req && lk_side) |=> !rsp_ifault);

    // R8
    iside_no_dfault_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (lk_req && !lk_side) |=> !rsp_dfault);

endmodule

// File: tb/vpt_tlb_tb.sv
module vpt_tlb_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [5:0]  wr_idx = '0;
    logic [31:0] wr_hi = '0, wr_lo = '0;
    logic [7:0]  wr_tid = '0;
    logic        pid_we = 1'b0;
    logic [7:0]  pid_in = '0;
    logic        lk_req = 1'b0, lk_side = 1'b0;
    logic [31:0] lk_ea = '0;
    logic        xlat_en_i = 1'b1, xlat_en_d = 1'b1;
    logic        rsp_valid, rsp_hit, rsp_ifault, rsp_dfault;
    logic [31:0] rsp_pa;

    int checks = 0;
    int fails  = 0;

    always #4 clk = ~clk;

    vpt_tlb u_dut (
        .clk(clk), .rst_n(rst_n),
        .wr_en(wr_en), .wr_idx(wr_idx), .wr_hi(wr_hi), .wr_lo(wr_lo), .wr_tid(wr_tid),
        .pid_we(pid_we), .pid_in(pid_in),
        .lk_req(lk_req), .lk_side(lk_side), .lk_ea(lk_ea),
        .xlat_en_i(xlat_en_i), .xlat_en_d(xlat_en_d),
        .rsp_valid(rsp_valid), .rsp_hit(rsp_hit), .rsp_ifault(rsp_ifault),
        .rsp_dfault(rsp_dfault), .rsp_pa(rsp_pa)
    );

    // Vector fields: side, en_i, en_d, ea[31:0], kind[1:0], pa[31:0]
    // kind: 0 hit, 1 pass-through, 2 instruction fault, 3 data fault
    localparam logic [68:0] VECS [0:12] = '{
        {1'b1, 1'b1, 1'b1, 32'h0000_12A4, 2'd0, 32'h8000_02A4}, // 1 KB page
        {1'b1, 1'b1, 1'b1, 32'h0000_1400, 2'd3, 32'h0000_0000}, // just past 1 KB
        {1'b0, 1'b1, 1'b1, 32'h1234_5678, 2'd0, 32'hAB34_5678}, // 16 MB beats later 16 KB
        {1'b1, 1'b1, 1'b1, 32'h4003_FFFC, 2'd0, 32'h0DDF_FFFC}, // 256 KB, other-TID entry skipped
        {1'b1, 1'b1, 1'b1, 32'h4004_0000, 2'd3, 32'h0000_0000}, // past 256 KB
        {1'b0, 1'b1, 1'b1, 32'h7F1A_BCDE, 2'd0, 32'h333A_BCDE}, // 1 MB, low-word junk dropped
        {1'b0, 1'b1, 1'b1, 32'h6000_0010, 2'd2, 32'h0000_0000}, // invalid entry
        {1'b1, 1'b1, 1'b1, 32'h0000_2ABC, 2'd0, 32'h0000_5ABC}, // 4 KB, high-word bits below mask ignored
        {1'b1, 1'b1, 1'b1, 32'h1300_0000, 2'd3, 32'h0000_0000}, // outside 16 MB
        {1'b0, 1'b0, 1'b1, 32'hDEAD_BEEF, 2'd1, 32'hDEAD_BEEF}, // instruction side off
        {1'b1, 1'b1, 1'b0, 32'h6000_0010, 2'd1, 32'h6000_0010}, // data side off
        {1'b0, 1'b1, 1'b0, 32'h6000_0010, 2'd2, 32'h0000_0000}, // data off, instruction on
        {1'b1, 1'b1, 1'b1, 32'h807F_FFFF, 2'd0, 32'h01FF_FFFF}  // 4 MB
    };

    function automatic logic [35:0] resp();
        return {rsp_valid, rsp_hit, rsp_ifault, rsp_dfault, rsp_pa};
    endfunction

    function automatic logic [35:0] mk(input logic [1:0] kind, input logic [31:0] pa);
        case (kind)
            2'd0:    return {4'b1100, pa};
            2'd1:    return {4'b1000, pa};
            2'd2:    return {4'b1010, 32'h0};
            default: return {4'b1001, 32'h0};
        endcase
    endfunction

    task automatic chk(input string req, input logic [35:0] act, input logic [35:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: got %h expected %h", req, act, exp);
        end
    endtask

    task automatic wr(input int idx, input logic [31:0] hi, input logic [31:0] lo, input logic [7:0] tid);
        @(negedge clk);
        wr_en = 1'b1; wr_idx = 6'(idx); wr_hi = hi; wr_lo = lo; wr_tid = tid;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic set_pid(input logic [7:0] p);
        @(negedge clk);
        pid_we = 1'b1; pid_in = p;
        @(negedge clk);
        pid_we = 1'b0;
    endtask

    task automatic look(input logic side, input logic [31:0] ea);
        @(negedge clk);
        lk_req = 1'b1; lk_side = side; lk_ea = ea;
        @(negedge clk);
        lk_req = 1'b0;
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
    endtask

    task automatic summary();
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        checks++;
        fails++;
        $display("FAIL watchdog: got timeout expected completion");
        summary();
        $finish;
    end

    initial begin
        do_reset();
        // R10 R1: outputs quiet after reset
        @(negedge clk);
        chk("R10 reset outputs", resp(), 36'h0);
        // R1: nothing valid yet
        look(1'b1, 32'h0000_1000);
        chk("R1 lookup after reset", resp(), mk(2'd3, 32'h0));

        // R11 R2: load PID and entries (hi: page 31:10, size 9:7, valid 6)
        set_pid(8'h05);
        wr(0,  32'h0000_1040, 32'h8000_0000, 8'h05); // 1 KB
        wr(1,  32'h1200_03C0, 32'hAB00_0000, 8'h05); // 16 MB
        wr(2,  32'h4000_01C0, 32'h0123_0000, 8'h09); // 64 KB, TID 9
        wr(3,  32'h4000_0240, 32'h0DDC_0000, 8'h05); // 256 KB
        wr(5,  32'h7F10_02C0, 32'h3331_2345, 8'h05); // 1 MB
        wr(6,  32'h6000_0000, 32'h1111_0000, 8'h05); // invalid
        wr(7,  32'h0000_2CC0, 32'h0000_5000, 8'h05); // 4 KB
        wr(8,  32'h8040_0340, 32'h01C0_0000, 8'h05); // 4 MB
        wr(10, 32'h1234_4140, 32'h5555_0000, 8'h05); // 16 KB inside idx 1

        // R4 R5 R6 R7 R8 R9: table walk
        for (int v = 0; v < 13; v++) begin
            logic [68:0] t;
            t = VECS[v];
            xlat_en_i = t[67];
            xlat_en_d = t[66];
            look(t[68], t[65:34]);
            chk($sformatf("R4 R5 R6 R7 R8 R9 vector %0d", v), resp(), mk(t[33:32], t[31:0]));
        end
        xlat_en_i = 1'b1;
        xlat_en_d = 1'b1;

        // R10: idle cycle after a response
        @(negedge clk);
        chk("R10 idle after response", resp(), 36'h0);

        // R3 R11: switch PID, the TID 9 entry becomes eligible, TID 5 ones drop out
        set_pid(8'h09);
        look(1'b1, 32'h4000_ABCD);
        chk("R3 R11 pid 9 hit", resp(), mk(2'd0, 32'h0123_ABCD));
        look(1'b1, 32'h0000_12A4);
        chk("R3 pid 9 excludes tid 5", resp(), mk(2'd3, 32'h0));
        set_pid(8'h05);

        // R7 R2: clear idx 1, the 16 KB entry now wins
        wr(1, 32'h1200_0380, 32'hAB00_0000, 8'h05);
        look(1'b0, 32'h1234_5678);
        chk("R7 R2 fallback to idx 10", resp(), mk(2'd0, 32'h5555_1678));

        // R2: load and lookup in one cycle, lookup sees old contents
        @(negedge clk);
        wr_en = 1'b1; wr_idx = 6'd1; wr_hi = 32'h1200_03C0; wr_lo = 32'hAB00_0000; wr_tid = 8'h05;
        lk_req = 1'b1; lk_side = 1'b0; lk_ea = 32'h1234_5678;
        @(negedge clk);
        wr_en = 1'b0; lk_req = 1'b0;
        chk("R2 same-cycle write unseen", resp(), mk(2'd0, 32'h5555_1678));
        look(1'b0, 32'h1234_5678);
        chk("R2 R7 reloaded idx 1 wins", resp(), mk(2'd0, 32'hAB34_5678));

        // R1 R11: second reset clears valid flags and PID
        do_reset();
        set_pid(8'h05);
        look(1'b1, 32'h0000_12A4);
        chk("R1 valid cleared by reset", resp(), mk(2'd3, 32'h0));
        look(1'b0, 32'h1234_5678);
        chk("R1 R8 instruction fault after reset", resp(), mk(2'd2, 32'h0));

        summary();
        $finish;
    end
endmodule